// File: doc/BRIEF.md
# Control Register Range Loader

This block fills a contiguous, circular run of a sixteen-entry bank of 32-bit control registers from consecutive words in memory. A caller pulses `start` with a first register index, a last register index and a byte address. The block then reads one memory word per register over a request/response port and writes each returned word into the next register in ascending index order. After index 15 the walk continues at index 0, so a first index above the last index selects a wrapped range.

The byte address must be word aligned. A misaligned address is refused at once. The block raises a one-cycle specification-error pulse, issues no memory request and leaves every register untouched. A completed load ends with a one-cycle `done` pulse. Memory is only ever read. The whole register bank is visible on a flat output bus so that neighbouring logic can decode it.

Top module: `ctl_bank_loader`

## Requirements
- R1: Registers are written in ascending index order, starting at the first index. The word fetched k-th (k from 0) lands in register (first + k) mod 16.
- R2: Index 0 follows index 15. A first index greater than the last index loads first..15 and then 0..last.
- R3: The number of words fetched is ((last - first) mod 16) + 1. Equal indices load exactly one register, and last = first - 1 (mod 16) loads all sixteen.
- R4: Request addresses start at the operand address and rise by 4 per word. A pending request holds its address until `mem_req_ready` is high.
- R5: An operand address with bits [1:0] not equal to 00 produces a one-cycle `spec_err` pulse in the cycle after `start`. It issues no memory request and changes no register.
- R6: A register changes only on the clock edge where `mem_rsp_valid` is high for the outstanding request. Nothing else in the bank changes. Memory is never written.
- R7: `done` is high for exactly one cycle, in the cycle after the final register write. `done` and `spec_err` are never high together.
- R8: A `start` pulse while `busy` is high is ignored. The load in progress completes with its original range and address.
- R9: After reset all registers read 0 and `busy`, `done`, `spec_err` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a load (sampled while idle) |
| first_idx | input | 4 | Index of the first register to load |
| last_idx | input | 4 | Index of the last register to load |
| opnd_addr | input | 32 | Byte address of the first source word |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned for the accepted request |
| mem_rsp_data | input | 32 | Returned word |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| spec_err | output | 1 | One-cycle pulse on a misaligned operand address |
| cregs_o | output | 512 | Register bank, register i at bits [32*i+31:32*i] |

## Verification
The bench goes after the wrapped range (14 to 2) and the full sixteen-word circle (5 to 4). A loader that stops at 15 would leave registers 0..2 stale there. A loader that computes the count without the modulo would fetch the wrong number of words. The single-register case (first equals last) catches an off-by-one count. A misaligned address checks that no request escapes and no register moves. A memory that withholds ready on alternate cycles tests that the address holds and that no register is written before its data arrives. A second `start` pulse during a load checks that the range is latched rather than re-sampled.

// File: rtl/ctl_load_pkg.sv
package ctl_load_pkg;

    localparam int CR_COUNT       = 16;
    localparam int CR_WIDTH       = 32;
    localparam int ADDR_WIDTH     = 32;
    localparam int IDX_W          = $clog2(CR_COUNT);
    localparam int BYTES_PER_WORD = CR_WIDTH / 8;
    localparam int ALIGN_BITS     = $clog2(BYTES_PER_WORD);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]      idx;
        logic [ADDR_WIDTH-1:0] addr;
        logic [IDX_W-1:0]      left;
    } cursor_t;

    function automatic logic word_aligned(input logic [ADDR_WIDTH-1:0] a);
        return a[ALIGN_BITS-1:0] == '0;
    endfunction

    function automatic logic [IDX_W-1:0] span_minus_one(
        input logic [IDX_W-1:0] lo, input logic [IDX_W-1:0] hi);
        return hi - lo;
    endfunction

endpackage

// File: rtl/ctl_load_cursor.sv
module ctl_load_cursor
    import ctl_load_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  launch,
    input  logic                  advance,
    input  logic [IDX_W-1:0]      first_idx,
    input  logic [IDX_W-1:0]      last_idx,
    input  logic [ADDR_WIDTH-1:0] base_addr,
    output cursor_t               cur,
    output logic                  is_last
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (launch) begin
            cur.idx  <= first_idx;
            cur.addr <= base_addr;
            cur.left <= span_minus_one(first_idx, last_idx);
        end else if (advance) begin
            cur.idx  <= cur.idx + 1'b1;
            cur.addr <= cur.addr + ADDR_WIDTH'(BYTES_PER_WORD);
            cur.left <= cur.left - 1'b1;
        end
    end

    assign is_last = (cur.left == '0);

endmodule

// File: rtl/ctl_load_fsm.sv
module ctl_load_fsm
    import ctl_load_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic aligned,
    input  logic req_ready,
    input  logic rsp_valid,
    input  logic is_last,
    output logic launch,
    output logic advance,
    output logic wr_en,
    output logic req_valid,
    output logic busy,
    output logic done,
    output logic spec_err
);

    seq_state_e state, state_nx;

    always_comb begin
        state_nx  = state;
        launch    = 1'b0;
        advance   = 1'b0;
        wr_en     = 1'b0;
        req_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start && aligned) begin
                    launch   = 1'b1;
                    state_nx = ST_REQ;
                end
            end
            ST_REQ: begin
                req_valid = 1'b1;
                if (req_ready) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    wr_en = 1'b1;
                    if (is_last) begin
                        state_nx = ST_IDLE;
                    end else begin
                        advance  = 1'b1;
                        state_nx = ST_REQ;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            spec_err <= 1'b0;
        end else begin
            state    <= state_nx;
            done     <= wr_en && is_last;
            spec_err <= (state == ST_IDLE) && start && !aligned;
        end
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
    import ctl_load_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [CR_WIDTH-1:0]          wr_data,
    output logic [CR_COUNT*CR_WIDTH-1:0] regs_flat
);

    for (genvar g = 0; g < CR_COUNT; g++) begin : g_cr
        logic [CR_WIDTH-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                        q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))        q <= wr_data;
        end
        assign regs_flat[g*CR_WIDTH +: CR_WIDTH] = q;
    end

endmodule

// File: rtl/ctl_bank_loader.sv
module ctl_bank_loader
    import ctl_load_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [IDX_W-1:0]             first_idx,
    input  logic [IDX_W-1:0]             last_idx,
    input  logic [ADDR_WIDTH-1:0]        opnd_addr,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [ADDR_WIDTH-1:0]        mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [CR_WIDTH-1:0]          mem_rsp_data,
    output logic                         busy,
    output logic                         done,
    output logic                         spec_err,
    output logic [CR_COUNT*CR_WIDTH-1:0] cregs_o
);

    logic    launch, advance, wr_en, is_last;
    cursor_t cur;

    ctl_load_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .aligned   (word_aligned(opnd_addr)),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .is_last   (is_last),
        .launch    (launch),
        .advance   (advance),
        .wr_en     (wr_en),
        .req_valid (mem_req_valid),
        .busy      (busy),
        .done      (done),
        .spec_err  (spec_err)
    );

    ctl_load_cursor u_cursor (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .advance   (advance),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .base_addr (opnd_addr),
        .cur       (cur),
        .is_last   (is_last)
    );

    ctl_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (cur.idx),
        .wr_data   (mem_rsp_data),
        .regs_flat (cregs_o)
    );

    assign mem_req_addr = cur.addr;

endmodule

// File: rtl/ctl_load_checker.sv
module ctl_load_checker
    import ctl_load_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         mem_req_valid,
    input logic                         mem_req_ready,
    input logic [ADDR_WIDTH-1:0]        mem_req_addr,
    input logic                         mem_rsp_valid,
    input logic                         busy,
    input logic                         done,
    input logic                         spec_err,
    input logic [CR_COUNT*CR_WIDTH-1:0] cregs_o
);

    assert_req_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ALIGN_BITS-1:0] == '0));

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_spec_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        spec_err |-> (!mem_req_valid && !busy));

    assert_regs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_rsp_valid |=> $stable(cregs_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_spec_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(done && spec_err));

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !spec_err);

endmodule

bind ctl_bank_loader ctl_load_checker u_ctl_load_checker (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (busy),
    .done          (done),
    .spec_err      (spec_err),
    .cregs_o       (cregs_o)
);

// File: tb/ctl_bank_loader_bench.sv
`timescale 1ns/1ps
module ctl_bank_loader_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   first_idx = '0;
    logic [3:0]   last_idx = '0;
    logic [31:0]  opnd_addr = '0;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_data = '0;
    logic         busy, done, spec_err;
    logic [511:0] cregs_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit stall_mode = 1'b0;

    logic [31:0] req_log [0:31];
    int          nlog = 0;
    logic [31:0] model [0:15];

    always #4 clk = ~clk;

    ctl_bank_loader u_ctl_bank_loader (
        .clk(clk), .rst(rst), .start(start), .first_idx(first_idx),
        .last_idx(last_idx), .opnd_addr(opnd_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
        .spec_err(spec_err), .cregs_o(cregs_o)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (mem_req_valid && mem_req_ready) begin
            if (nlog < 32) req_log[nlog] = mem_req_addr;
            nlog++;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_word(mem_req_addr);
        end else begin
            mem_rsp_valid <= 1'b0;
        end
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected <100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < 16; i++)
            if (cregs_o[i*32 +: 32] !== model[i]) begin ok = 1'b0; bad = i; end
        check(ok, req, cregs_o[bad*32 +: 32], model[bad]);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) model[i] = '0;
        check_bank("R9 bank zero after reset");
        check({busy, done, spec_err, mem_req_valid} == 4'b0, "R9 idle outputs after reset",
              {28'b0, busy, done, spec_err, mem_req_valid}, 32'h0);
    endtask

    // drives one load and checks count, addresses, contents and done pulse
    task automatic test_range(input logic [3:0] f, input logic [3:0] l,
                              input logic [31:0] a, input bit stall,
                              input bit poke_busy, input string req);
        int  n = ((int'(l) - int'(f)) & 15) + 1;
        bit  saw_done = 1'b0;
        bit  saw_err = 1'b0;
        stall_mode = stall;
        nlog = 0;
        @(negedge clk);
        first_idx = f; last_idx = l; opnd_addr = a; start = 1'b1;
        for (int it = 0; it < 300 && !saw_done; it++) begin
            @(negedge clk);
            if (it == 0) start = 1'b0;
            if (poke_busy && it == 3) begin
                first_idx = f + 4'd1; last_idx = f + 4'd1;
                opnd_addr = a + 32'h100; start = 1'b1;
            end
            if (poke_busy && it == 4) start = 1'b0;
            if (spec_err) saw_err = 1'b1;
            if (done) saw_done = 1'b1;
        end
        check(saw_done, {req, " done seen"}, {31'b0, saw_done}, 32'h1);
        check(!saw_err, {req, " no spec_err on aligned load"}, {31'b0, saw_err}, 32'h0);
        check(nlog == n, {req, " R3 word count"}, nlog, n);
        for (int k = 0; k < n && k < nlog; k++) begin
            check(req_log[k] == a + 32'(4*k), {req, " R4 request address"},
                  req_log[k], a + 32'(4*k));
            model[(int'(f) + k) & 15] = mem_word(a + 32'(4*k));
        end
        check_bank({req, " R1 R6 bank contents"});
        @(negedge clk);
        check(!done, {req, " R7 done one cycle"}, {31'b0, done}, 32'h0);
        check(!busy, {req, " idle after done"}, {31'b0, busy}, 32'h0);
        stall_mode = 1'b0;
    endtask

    task automatic test_misaligned(input logic [31:0] a);
        bit saw_err = 1'b0;
        nlog = 0;
        @(negedge clk);
        first_idx = 4'd3; last_idx = 4'd9; opnd_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        saw_err = spec_err;
        check(saw_err, "R5 spec_err in cycle after start", {31'b0, spec_err}, 32'h1);
        @(negedge clk);
        check(!spec_err, "R5 spec_err one cycle", {31'b0, spec_err}, 32'h0);
        repeat (4) @(negedge clk);
        check(nlog == 0, "R5 no memory request", nlog, 0);
        check(!busy && !done, "R5 R7 no load started", {30'b0, busy, done}, 32'h0);
        check_bank("R5 bank unchanged");
    endtask

    initial begin
        test_reset();
        test_range(4'd2,  4'd5,  32'h0000_1000, 1'b0, 1'b0, "R1 plain range");
        test_range(4'd7,  4'd7,  32'h0000_2040, 1'b0, 1'b0, "R3 single register");
        test_range(4'd14, 4'd2,  32'h0000_3000, 1'b0, 1'b0, "R2 wrapped range");
        test_range(4'd5,  4'd4,  32'h0000_4000, 1'b0, 1'b0, "R3 full circle");
        test_range(4'd9,  4'd12, 32'hFFFF_FFF8, 1'b1, 1'b0, "R4 stalled ready");
        test_misaligned(32'h0000_5002);
        test_misaligned(32'h0000_5001);
        test_range(4'd0,  4'd6,  32'h0000_6000, 1'b1, 1'b1, "R8 start while busy");
        test_range(4'd15, 4'd0,  32'h0000_7000, 1'b0, 1'b0, "R2 wrap 15 to 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule